// File: doc/BRIEF.md
# ADC Sample and Convert Sequencer

This block is the digital controller that sits around a successive-approximation converter. It runs a four-state machine that moves through idle, acquisition, conversion and a short post-abort lockout. It times every interval in units of a conversion clock period (TAD). The TAD length is set by a 6-bit divide field `adcs` and equals (adcs+1)/2 cycles of `clk`, so the period can be set in half-cycle steps.

Software starts acquisition with a rising edge on `samp`. The `trig_sel` field then chooses what ends acquisition and starts conversion:
- a falling edge on `samp`;
- an automatic count of `samc` TAD periods, where 0 is treated as 1;
- a rising edge on one of the synchronised `ext_trig` inputs, which stand for timer, PWM or interrupt sources.

The analog sampler is not part of the block. In its place the block captures the digital `sample_in` word at the moment conversion starts. After 13 TAD periods it presents that word on `result` and signals completion.

Dropping `en` while the block is acquiring or converting aborts the sequence. The result buffer keeps its old value, and new sample starts are refused for 2 TAD periods.

The states are ST_IDLE, ST_ACQ, ST_CONV and ST_LOCK. The transitions are:
- T_START: ST_IDLE to ST_ACQ, on a `samp` rise while enabled.
- T_TRIGGER: ST_ACQ to ST_CONV, on the selected trigger.
- T_COMPLETE: ST_CONV to ST_IDLE, after 13 TAD.
- T_ABORT: ST_ACQ or ST_CONV to ST_LOCK, when `en` is low.
- T_RELEASE: ST_LOCK to ST_IDLE, after 2 TAD.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset `result` is 0 and `sampling`, `converting`, `done_pulse` and `done_flag` are all low.
- R2: The timed intervals last ceil(n*(adcs+1)/2) clock cycles, where n is the interval length in TAD periods. This gives one TAD = (adcs+1)/2 cycles.
- R3: A rising edge on `samp` while `en` is high and the block is idle makes `sampling` go high on the next cycle and clears `done_flag`.
- R4: With trig_sel = 3'b000, a falling edge on `samp` during acquisition starts conversion. `sample_in` is captured on that same clock edge, and later changes to `sample_in` do not alter the result.
- R5: With trig_sel = 3'b111, acquisition lasts ceil(max(samc,1)*(adcs+1)/2) cycles, after which conversion starts.
- R6: With trig_sel = k, where k is 1 to 6, conversion starts on the third clock edge after `ext_trig[k-1]` rises. Edges on unselected inputs, and edges that arrive while the block is not sampling, are ignored.
- R7: `converting` stays high for ceil(13*(adcs+1)/2) cycles. On the next cycle `result` holds the captured sample.
- R8: `done_pulse` is high for exactly one cycle, in the cycle `result` updates. `done_flag` is set in that same cycle and stays set until the next R3 start.
- R9: `en` low during conversion aborts it. `result` keeps its previous value and no `done_pulse` or `done_flag` is produced.
- R10: `en` low in the same cycle that the automatic trigger would fire aborts the sequence, and no conversion starts.
- R11: After an abort the block ignores `samp` rising edges for adcs+1 cycles (2 TAD). After that it accepts a new start.
- R12: A rising edge on `samp` while `en` is low starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Converter enable; low aborts |
| samp | input | 1 | Software sample control level |
| trig_sel | input | 3 | Trigger source select |
| samc | input | SAMC_W | Auto-start acquisition length in TAD |
| adcs | input | DIV_W | Conversion clock divide setting |
| ext_trig | input | NUM_EXT | Asynchronous external trigger inputs |
| sample_in | input | DATA_W | Digital stand-in for the sampled value |
| result | output | DATA_W | Result buffer |
| done_pulse | output | 1 | One-cycle completion strobe |
| done_flag | output | 1 | Sticky completion flag |
| sampling | output | 1 | High during acquisition |
| converting | output | 1 | High during conversion |

## Verification
The bench measures conversion length for odd and even values of adcs+1, including adcs = 0 and adcs = 63. A divider that rounded a half TAD down, or counted whole cycles only, would finish one cycle early or run twice too long.

It sets samc to 0 in auto mode, so a design that skipped the floor of one would trigger at once or wrap its count. It drops `en` in the exact cycle the automatic trigger would fire, so a design giving the trigger priority would start a conversion.

It aborts mid-conversion and then raises `samp` inside the lockout. A design that wrote partial data, raised the done flag, or accepted the early start would show it on `result` or `sampling`. External edges are sent on an unselected input and while idle, so a design that failed to gate them would leave acquisition early.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACQ  = 2'd1,
        ST_CONV = 2'd2,
        ST_LOCK = 2'd3
    } seq_state_t;

    localparam logic [2:0] TRIG_SOFT = 3'b000;
    localparam logic [2:0] TRIG_AUTO = 3'b111;

    localparam int CONV_TADS = 13;
    localparam int LOCK_TADS = 2;

endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
    parameter int NUM = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] trig_in,
    output logic [NUM-1:0] trig_rise
);

    localparam int DEPTH = 3;

    for (genvar g = 0; g < NUM; g++) begin : g_lane
        logic [DEPTH-1:0] shr;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shr <= '0;
            end else begin
                shr <= {shr[DEPTH-2:0], trig_in[g]};
            end
        end

        // stage 1 and 2 synchronise, stage 3 holds the previous level
        assign trig_rise[g] = shr[1] & ~shr[2];
    end

endmodule

// File: rtl/adc_tad_timer.sv
module adc_tad_timer #(
    parameter int DIV_W = 6,
    parameter int TW    = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [DIV_W-1:0] adcs,
    input  logic [TW-1:0]    tads,
    output logic             expire
);

    // Count in half instruction cycles: every clock adds two halves,
    // one TAD spans adcs+1 halves.
    logic [TW-1:0] halves;
    logic [TW-1:0] target;

    assign target = tads * (TW'(adcs) + TW'(1));
    assign expire = (halves + TW'(2)) >= target;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halves <= '0;
        end else if (clear) begin
            halves <= '0;
        end else if (!expire) begin
            halves <= halves + TW'(2);
        end
    end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int DATA_W  = 12,
    parameter int SAMC_W  = 5,
    parameter int NUM_EXT = 6,
    parameter int TW      = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               samp,
    input  logic [2:0]         trig_sel,
    input  logic [SAMC_W-1:0]  samc,
    input  logic [NUM_EXT-1:0] ext_rise,
    input  logic               tmr_expire,
    input  logic [DATA_W-1:0]  sample_in,
    output logic               tmr_clear,
    output logic [TW-1:0]      tmr_tads,
    output logic [DATA_W-1:0]  result,
    output logic               done_pulse,
    output logic               done_flag,
    output logic               sampling,
    output logic               converting
);

    seq_state_t        st;
    seq_state_t        nxt;
    logic              samp_q;
    logic              samp_rise;
    logic              samp_fall;
    logic              ext_hit;
    logic              fire;
    logic [SAMC_W-1:0] samc_eff;
    logic [DATA_W-1:0] held;

    assign samp_rise = samp & ~samp_q;
    assign samp_fall = ~samp & samp_q;
    assign samc_eff  = (samc == '0) ? SAMC_W'(1) : samc;

    always_comb begin
        ext_hit = 1'b0;
        for (int i = 0; i < NUM_EXT; i++) begin
            if (int'(trig_sel) == i + 1) begin
                ext_hit = ext_rise[i];
            end
        end
    end

    always_comb begin
        unique case (trig_sel)
            TRIG_SOFT: fire = samp_fall;
            TRIG_AUTO: fire = tmr_expire;
            default:   fire = ext_hit;
        endcase
    end

    // next state: abort checked before any trigger or completion
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: if (en && samp_rise) nxt = ST_ACQ;          // T_START
            ST_ACQ: begin
                if (!en)       nxt = ST_LOCK;                      // T_ABORT
                else if (fire) nxt = ST_CONV;                      // T_TRIGGER
            end
            ST_CONV: begin
                if (!en)             nxt = ST_LOCK;                // T_ABORT
                else if (tmr_expire) nxt = ST_IDLE;                // T_COMPLETE
            end
            ST_LOCK: if (tmr_expire) nxt = ST_IDLE;              // T_RELEASE
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (st)
            ST_ACQ:  tmr_tads = TW'(samc_eff);
            ST_CONV: tmr_tads = TW'(CONV_TADS);
            ST_LOCK: tmr_tads = TW'(LOCK_TADS);
            default: tmr_tads = '0;
        endcase
    end

    assign tmr_clear  = (nxt != st) || (st == ST_IDLE);
    assign sampling   = (st == ST_ACQ);
    assign converting = (st == ST_CONV);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= nxt;
        end
    end

    // registered outputs and data path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q     <= 1'b0;
            held       <= '0;
            result     <= '0;
            done_pulse <= 1'b0;
            done_flag  <= 1'b0;
        end else begin
            samp_q     <= samp;
            done_pulse <= 1'b0;
            if (st == ST_IDLE && nxt == ST_ACQ) begin
                done_flag <= 1'b0;
            end
            if (st == ST_ACQ && nxt == ST_CONV) begin
                held <= sample_in;
            end
            if (st == ST_CONV && nxt == ST_IDLE) begin
                result     <= held;
                done_pulse <= 1'b1;
                done_flag  <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int DATA_W  = 12,
    parameter int DIV_W   = 6,
    parameter int SAMC_W  = 5,
    parameter int NUM_EXT = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               samp,
    input  logic [2:0]         trig_sel,
    input  logic [SAMC_W-1:0]  samc,
    input  logic [DIV_W-1:0]   adcs,
    input  logic [NUM_EXT-1:0] ext_trig,
    input  logic [DATA_W-1:0]  sample_in,
    output logic [DATA_W-1:0]  result,
    output logic               done_pulse,
    output logic               done_flag,
    output logic               sampling,
    output logic               converting
);

    localparam int TW = SAMC_W + DIV_W + 2;

    logic [NUM_EXT-1:0] ext_rise;
    logic               tmr_clear;
    logic               tmr_expire;
    logic [TW-1:0]      tmr_tads;

    adc_trig_sync #(.NUM(NUM_EXT)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_in   (ext_trig),
        .trig_rise (ext_rise)
    );

    adc_tad_timer #(.DIV_W(DIV_W), .TW(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (tmr_clear),
        .adcs   (adcs),
        .tads   (tmr_tads),
        .expire (tmr_expire)
    );

    adc_seq_fsm #(
        .DATA_W  (DATA_W),
        .SAMC_W  (SAMC_W),
        .NUM_EXT (NUM_EXT),
        .TW      (TW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .samp       (samp),
        .trig_sel   (trig_sel),
        .samc       (samc),
        .ext_rise   (ext_rise),
        .tmr_expire (tmr_expire),
        .sample_in  (sample_in),
        .tmr_clear  (tmr_clear),
        .tmr_tads   (tmr_tads),
        .result     (result),
        .done_pulse (done_pulse),
        .done_flag  (done_flag),
        .sampling   (sampling),
        .converting (converting)
    );

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [DATA_W-1:0] result,
    input logic              done_pulse,
    input logic              done_flag,
    input logic              sampling,
    input logic              converting
);

    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sampling && converting)); // R3

    AST_CONV_FROM_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(converting) |-> $past(sampling)); // R4

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse); // R8

    AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> done_flag); // R8

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_pulse |-> $stable(result)); // R9

    AST_ABORT_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        (converting && !en) |=> (!converting && !done_pulse)); // R9

    AST_ABORT_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
        (sampling && !en) |=> (!converting && !sampling)); // R10

    AST_OFF_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!sampling && !converting && !en) |=> !sampling); // R12

endmodule

bind adc_seq_ctrl adc_seq_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .result     (result),
    .done_pulse (done_pulse),
    .done_flag  (done_flag),
    .sampling   (sampling),
    .converting (converting)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
    localparam int DW = 12;
    localparam int DV = 6;
    localparam int SW = 5;
    localparam int NE = 6;

    logic          clk = 1'b0;
    logic          rst_n, en, samp;
    logic [2:0]    trig_sel;
    logic [SW-1:0] samc;
    logic [DV-1:0] adcs;
    logic [NE-1:0] ext_trig;
    logic [DW-1:0] sample_in;
    logic [DW-1:0] result;
    logic          done_pulse, done_flag, sampling, converting;

    int  checks = 0;
    int  fails  = 0;
    bit  reported = 0;

    always #10 clk = ~clk;

    adc_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .samp(samp), .trig_sel(trig_sel),
        .samc(samc), .adcs(adcs), .ext_trig(ext_trig), .sample_in(sample_in),
        .result(result), .done_pulse(done_pulse), .done_flag(done_flag),
        .sampling(sampling), .converting(converting)
    );

    function automatic int cyc(int tads, int a);
        return (tads * (a + 1) + 1) / 2;
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int            ms;      // 0 idle, 1 acquire, 2 convert, 3 lockout
    int            remain;
    logic [DW-1:0] m_res, m_hold;
    bit            m_pulse, m_flag, sp;
    logic [NE-1:0] h1, h2, h3;

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; remain = 0; m_res = '0; m_hold = '0;
            m_pulse = 0; m_flag = 0; sp = 0; h1 = '0; h2 = '0; h3 = '0;
        end else begin
            logic [NE-1:0] edges;
            bit rise, fall, hit;
            int se;
            edges = h2 & ~h3;
            h3 = h2; h2 = h1; h1 = ext_trig;
            rise = samp && !sp;
            fall = !samp && sp;
            se = (samc == 0) ? 1 : int'(samc);
            m_pulse = 0;
            case (ms)
                0: if (en && rise) begin
                       ms = 1; remain = cyc(se, adcs); m_flag = 0;
                   end
                1: begin
                       if (trig_sel == 3'b000)      hit = fall;
                       else if (trig_sel == 3'b111) hit = (remain == 1);
                       else                         hit = edges[trig_sel - 1];
                       if (!en) begin
                           ms = 3; remain = cyc(2, adcs);
                       end else if (hit) begin
                           ms = 2; m_hold = sample_in; remain = cyc(13, adcs);
                       end else if (remain > 1) begin
                           remain--;
                       end
                   end
                2: begin
                       if (!en) begin
                           ms = 3; remain = cyc(2, adcs);
                       end else if (remain == 1) begin
                           ms = 0; m_res = m_hold; m_pulse = 1; m_flag = 1;
                       end else begin
                           remain--;
                       end
                   end
                default: if (remain == 1) ms = 0; else remain--;
            endcase
            sp = samp;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3", "sampling vs model", sampling, ms == 1);
            chk("R7", "converting vs model", converting, ms == 2);
            chk("R7", "result vs model", result, m_res);
            chk("R8", "done_pulse vs model", done_pulse, m_pulse);
            chk("R8", "done_flag vs model", done_flag, m_flag);
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic run_soft(int a, logic [DW-1:0] d);
        int n;
        adcs = DV'(a); trig_sel = 3'b000; sample_in = d;
        samp = 1'b1;
        @(negedge clk);
        chk("R3", "sampling after samp rise", sampling, 1);
        chk("R3", "done_flag cleared on start", done_flag, 0);
        repeat (2) @(negedge clk);
        samp = 1'b0;
        @(negedge clk);
        sample_in = ~d;           // R4: must not leak into the result
        n = 0;
        while (converting) begin
            n++;
            @(negedge clk);
        end
        chk("R7", "conversion cycles", n, cyc(13, a));
        chk("R2", "conversion cycles for adcs", n, (13 * (a + 1) + 1) / 2);
        chk("R4", "latched sample", result, d);
        chk("R8", "done_pulse on update", done_pulse, 1);
        chk("R8", "done_flag set", done_flag, 1);
        @(negedge clk);
        chk("R8", "done_pulse one cycle", done_pulse, 0);
    endtask

    task automatic run_auto(int a, int s, logic [DW-1:0] d);
        int n;
        int se;
        se = (s == 0) ? 1 : s;
        adcs = DV'(a); samc = SW'(s); trig_sel = 3'b111; sample_in = d;
        samp = 1'b1;
        @(negedge clk);
        n = 0;
        while (sampling) begin
            n++;
            @(negedge clk);
        end
        chk("R5", "auto acquisition cycles", n, cyc(se, a));
        chk("R5", "conversion follows auto start", converting, 1);
        while (converting) @(negedge clk);
        chk("R7", "auto result", result, d);
        samp = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        logic [DW-1:0] prev;
        rst_n = 1'b0; en = 1'b0; samp = 1'b0; trig_sel = 3'b000;
        samc = '0; adcs = '0; ext_trig = '0; sample_in = '0;
        repeat (3) @(negedge clk);
        chk("R1", "reset result", result, 0);
        chk("R1", "reset sampling", sampling, 0);
        chk("R1", "reset converting", converting, 0);
        chk("R1", "reset done_pulse", done_pulse, 0);
        chk("R1", "reset done_flag", done_flag, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: start request while disabled
        samp = 1'b1;
        repeat (4) @(negedge clk);
        chk("R12", "no start while disabled", sampling, 0);
        samp = 1'b0; en = 1'b1;
        repeat (2) @(negedge clk);

        // R2 / R7: several divide settings, odd and even
        run_soft(0, 12'h5A3);
        run_soft(1, 12'h0F1);
        run_soft(2, 12'hA0C);
        run_soft(5, 12'h333);
        run_soft(63, 12'hFFE);

        // R5: auto start, including samc = 0
        run_auto(0, 0, 12'h111);
        run_auto(3, 0, 12'h222);
        run_auto(3, 4, 12'h444);
        run_auto(6, 7, 12'h777);

        // R9 / R11: abort mid-conversion, then samp rise in lockout
        prev = result;
        adcs = 7; trig_sel = 3'b000; sample_in = 12'hBAD;
        samp = 1'b1;
        repeat (2) @(negedge clk);
        samp = 1'b0;
        @(negedge clk);
        chk("R4", "converting after samp fall", converting, 1);
        repeat (5) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk("R9", "abort stops conversion", converting, 0);
        en = 1'b1; samp = 1'b1;
        repeat (10) @(negedge clk);
        chk("R11", "start ignored in lockout", sampling, 0);
        chk("R9", "result untouched by abort", result, prev);
        chk("R9", "no done_flag after abort", done_flag, 0);
        samp = 1'b0;
        @(negedge clk);
        samp = 1'b1;
        @(negedge clk);
        chk("R11", "start accepted after lockout", sampling, 1);
        samp = 1'b0;
        @(negedge clk);
        while (converting) @(negedge clk);
        chk("R7", "result after recovery", result, 12'hBAD);
        repeat (2) @(negedge clk);

        // R10: abort in the cycle the auto trigger fires
        prev = result;
        adcs = 1; samc = 1; trig_sel = 3'b111; sample_in = 12'h0DD;
        samp = 1'b1;
        @(negedge clk);
        chk("R10", "sampling before abort", sampling, 1);
        en = 1'b0;
        @(negedge clk);
        chk("R10", "no conversion on tie", converting, 0);
        chk("R10", "no sampling on tie", sampling, 0);
        en = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10", "result unchanged on tie", result, prev);
        samp = 1'b0;
        repeat (3) @(negedge clk);

        // R6: external trigger on input 2 (trig_sel = 3)
        adcs = 2; trig_sel = 3'd3; sample_in = 12'h6E6;
        ext_trig[2] = 1'b1;
        @(negedge clk);
        ext_trig = '0;
        repeat (5) @(negedge clk);
        chk("R6", "idle edge ignored", sampling, 0);
        samp = 1'b1;
        @(negedge clk);
        ext_trig[0] = 1'b1;
        @(negedge clk);
        ext_trig = '0;
        repeat (5) @(negedge clk);
        chk("R6", "unselected edge ignored (sampling)", sampling, 1);
        chk("R6", "unselected edge ignored (converting)", converting, 0);
        ext_trig[2] = 1'b1;
        @(negedge clk);
        ext_trig = '0;
        @(negedge clk);
        chk("R6", "no start before sync delay", converting, 0);
        @(negedge clk);
        chk("R6", "start after sync delay", converting, 1);
        while (converting) @(negedge clk);
        chk("R6", "external result", result, 12'h6E6);
        repeat (6) @(negedge clk);
        chk("R8", "done_flag sticky", done_flag, 1);
        samp = 1'b0;
        repeat (3) @(negedge clk);

        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        report();
    end

endmodule